// File: doc/BRIEF.md
# Packet-Filter Register File with Call Tracking

This block holds the architectural registers of a small RISC-style packet-filter engine. It has eleven 64-bit entries. Entries 0 to 9 are general purpose. Entry 10 is a frame pointer, which the program may read but never write. Each entry carries a readability bit. A read of an entry that is not readable returns zero and latches a sticky error output.

Two combinational read ports serve the execution pipeline, and one write port takes either a full 64-bit value or a 32-bit subregister value. A 32-bit write is zero-extended. When a call to a host function returns, the return value is loaded into entry 0 and the argument entries 1 to 5 become unreadable. Entries 6 to 9 are untouched, so the callee-saved values survive the call.

A start pulse prepares a new program. It places the context pointer in entry 1, loads the frame base into entry 10, leaves only those two entries readable, and clears the error. Only one update happens per cycle, in the priority order start, then call return, then write. A lower-priority request in the same cycle is dropped.

Top module: `pfx_regfile`

## Requirements
- R1: After reset every entry holds zero, only entries 1 and 10 are readable, and `err` is 0.
- R2: A `start` pulse loads `ctx_ptr` into entry 1 and `frame_base` into entry 10, makes exactly entries 1 and 10 readable, and clears `err`. All of this is visible the next cycle.
- R3: A write with `wr_sub`=0 to an entry 0 to 9 stores all 64 bits of `wr_data` and makes the entry readable from the next cycle.
- R4: A write with `wr_sub`=1 stores `wr_data[31:0]` in bits 31:0 and zeroes bits 63:32.
- R5: A write to an index 10 to 15 leaves every entry unchanged, including entry 10, and sets `err` the next cycle.
- R6: A call return (`ret_en`) loads `ret_val` into entry 0, makes entry 0 readable, and makes entries 1 to 5 unreadable.
- R7: Across a call return, entries 6 to 9 keep their values and their readability.
- R8: An enabled read of an unreadable entry, or of an index 11 to 15, returns zero and sets `err` the next cycle. `err` stays 1 until the next `start`. A read with its enable at 0 never sets `err`, and its data is still zero when the entry is unreadable.
- R9: Priority is `start` over `ret_en` over `wr_en`. A write that loses arbitration changes nothing and raises no error.
- R10: The two read ports are independent. A read in the same cycle as a write to that entry returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Program start: load context and frame base |
| ctx_ptr | input | 64 | Context pointer placed in entry 1 on start |
| frame_base | input | 64 | Frame pointer value placed in entry 10 on start |
| ret_en | input | 1 | Call-return event |
| ret_val | input | 64 | Value returned by the called function |
| wr_en | input | 1 | Write request |
| wr_sub | input | 1 | 1: 32-bit zero-extended write, 0: full 64-bit write |
| wr_idx | input | 4 | Write target index |
| wr_data | input | 64 | Write data |
| rd_en_a | input | 1 | Port A read is architecturally used |
| rd_idx_a | input | 4 | Port A index |
| rd_data_a | output | 64 | Port A data, zero when the entry is unreadable |
| rd_en_b | input | 1 | Port B read is architecturally used |
| rd_idx_b | input | 4 | Port B index |
| rd_data_b | output | 64 | Port B data, zero when the entry is unreadable |
| err | output | 1 | Sticky access-violation flag |

## Verification
Full writes of all-ones patterns are followed by subregister writes to the same entry. This separates correct zero-extension from a merge that keeps the old upper half.

Calls are issued after entries 1 to 9 have all been made readable. This shows whether a return clobbers exactly the argument range and nothing on either side of it.

Simultaneous start, return and write requests expose the priority order. Same-cycle read-and-write pairs show whether a read sees old or new data.

Long random mixes of enabled reads, disabled reads and out-of-range indices exercise the sticky error against its clearing on start.

// File: rtl/pfx_rf_pkg.sv
package pfx_rf_pkg;
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_START = 2'd1,
    UPD_RET   = 2'd2,
    UPD_WR    = 2'd3
  } rf_upd_e;
endpackage

// File: rtl/pfx_rf_arb.sv
module pfx_rf_arb #(
  parameter int IDXW   = 4,
  parameter int FP_IDX = 10
) (
  input  logic                 start,
  input  logic                 ret_en,
  input  logic                 wr_en,
  input  logic [IDXW-1:0]      wr_idx,
  output pfx_rf_pkg::rf_upd_e  kind,
  output logic                 wr_bad
);
  import pfx_rf_pkg::*;

  logic wr_legal;

  always_comb begin
    wr_legal = (wr_idx < FP_IDX[IDXW-1:0]);
    wr_bad   = 1'b0;
    if (start) begin
      kind = UPD_START;
    end else if (ret_en) begin
      kind = UPD_RET;
    end else if (wr_en && wr_legal) begin
      kind = UPD_WR;
    end else begin
      kind   = UPD_NONE;
      wr_bad = wr_en;
    end
  end
endmodule

// File: rtl/pfx_rf_entry.sv
module pfx_rf_entry #(
  parameter int XLEN    = 64,
  parameter int SUBW    = 32,
  parameter int IDXW    = 4,
  parameter int IDX     = 0,
  parameter int RET_IDX = 0,
  parameter int CTX_IDX = 1,
  parameter int ARG_LO  = 1,
  parameter int ARG_HI  = 5,
  parameter int FP_IDX  = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pfx_rf_pkg::rf_upd_e kind,
  input  logic [IDXW-1:0]     wr_idx,
  input  logic                wr_sub,
  input  logic [XLEN-1:0]     wr_data,
  input  logic [XLEN-1:0]     ret_val,
  input  logic [XLEN-1:0]     ctx_val,
  input  logic [XLEN-1:0]     fp_base,
  output logic [XLEN-1:0]     q,
  output logic                vld
);
  import pfx_rf_pkg::*;

  localparam bit IS_FP   = (IDX == FP_IDX);
  localparam bit IS_CTX  = (IDX == CTX_IDX);
  localparam bit IS_RET  = (IDX == RET_IDX);
  localparam bit IS_ARG  = (IDX >= ARG_LO) && (IDX <= ARG_HI);
  localparam bit RST_VLD = IS_FP || IS_CTX;

  logic [XLEN-1:0] d_q, d_n;
  logic            v_q, v_n, ld;

  always_comb begin
    d_n = d_q;
    v_n = v_q;
    ld  = 1'b0;
    unique case (kind)
      UPD_START: begin
        ld = 1'b1;
        if (IS_CTX) begin
          d_n = ctx_val;
          v_n = 1'b1;
        end else if (IS_FP) begin
          d_n = fp_base;
          v_n = 1'b1;
        end else begin
          v_n = 1'b0;
        end
      end
      UPD_RET: begin
        if (IS_RET) begin
          ld  = 1'b1;
          d_n = ret_val;
          v_n = 1'b1;
        end else if (IS_ARG) begin
          ld  = 1'b1;
          v_n = 1'b0;
        end
      end
      UPD_WR: begin
        if (!IS_FP && (wr_idx == IDX[IDXW-1:0])) begin
          ld  = 1'b1;
          d_n = wr_sub ? {{(XLEN-SUBW){1'b0}}, wr_data[SUBW-1:0]} : wr_data;
          v_n = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= '0;
      v_q <= RST_VLD;
    end else if (ld) begin
      d_q <= d_n;
      v_q <= v_n;
    end
  end

  assign q   = d_q;
  assign vld = v_q;
endmodule

// File: rtl/pfx_rf_rdport.sv
module pfx_rf_rdport #(
  parameter int XLEN = 64,
  parameter int NREG = 11,
  parameter int IDXW = 4
) (
  input  logic            en,
  input  logic [IDXW-1:0] idx,
  input  logic [XLEN-1:0] q [NREG],
  input  logic [NREG-1:0] vld,
  output logic [XLEN-1:0] data,
  output logic            bad
);
  logic hit;

  always_comb begin
    data = '0;
    hit  = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if ((idx == i[IDXW-1:0]) && vld[i]) begin
        data = q[i];
        hit  = 1'b1;
      end
    end
    bad = en && !hit;
  end
endmodule

// File: rtl/pfx_regfile.sv
module pfx_regfile #(
  parameter int XLEN    = 64,
  parameter int NREG    = 11,
  parameter int NARG    = 5,
  parameter int IDXW    = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [XLEN-1:0] ctx_ptr,
  input  logic [XLEN-1:0] frame_base,
  input  logic            ret_en,
  input  logic [XLEN-1:0] ret_val,
  input  logic            wr_en,
  input  logic            wr_sub,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            rd_en_a,
  input  logic [IDXW-1:0] rd_idx_a,
  output logic [XLEN-1:0] rd_data_a,
  input  logic            rd_en_b,
  input  logic [IDXW-1:0] rd_idx_b,
  output logic [XLEN-1:0] rd_data_b,
  output logic            err
);
  import pfx_rf_pkg::*;

  localparam int SUBW    = XLEN / 2;
  localparam int FP_IDX  = NREG - 1;
  localparam int RET_IDX = 0;
  localparam int CTX_IDX = 1;
  localparam int ARG_LO  = 1;
  localparam int ARG_HI  = NARG;

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  rf_upd_e         kind;
  logic            wr_bad;
  logic [XLEN-1:0] rf_q [NREG];
  logic [NREG-1:0] rf_vld;
  logic            bad_a, bad_b;
  logic            err_q, err_n;

  pfx_rf_arb #(.IDXW(IDXW), .FP_IDX(FP_IDX)) u_arb (
    .start  (start),
    .ret_en (ret_en),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .kind   (kind),
    .wr_bad (wr_bad)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    pfx_rf_entry #(
      .XLEN(XLEN), .SUBW(SUBW), .IDXW(IDXW), .IDX(g),
      .RET_IDX(RET_IDX), .CTX_IDX(CTX_IDX),
      .ARG_LO(ARG_LO), .ARG_HI(ARG_HI), .FP_IDX(FP_IDX)
    ) u_ent (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .kind    (kind),
      .wr_idx  (wr_idx),
      .wr_sub  (wr_sub),
      .wr_data (wr_data),
      .ret_val (ret_val),
      .ctx_val (ctx_ptr),
      .fp_base (frame_base),
      .q       (rf_q[g]),
      .vld     (rf_vld[g])
    );
  end

  pfx_rf_rdport #(.XLEN(XLEN), .NREG(NREG), .IDXW(IDXW)) u_rd_a (
    .en (rd_en_a), .idx (rd_idx_a), .q (rf_q), .vld (rf_vld),
    .data (rd_data_a), .bad (bad_a)
  );

  pfx_rf_rdport #(.XLEN(XLEN), .NREG(NREG), .IDXW(IDXW)) u_rd_b (
    .en (rd_en_b), .idx (rd_idx_b), .q (rf_q), .vld (rf_vld),
    .data (rd_data_b), .bad (bad_b)
  );

  always_comb begin
    if (start) err_n = 1'b0;
    else       err_n = err_q | bad_a | bad_b | wr_bad;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) err_q <= 1'b0;
    else          err_q <= err_n;
  end

  assign err = err_q;
endmodule

// File: rtl/pfx_regfile_chk.sv
module pfx_regfile_chk #(
  parameter int XLEN = 64,
  parameter int NREG = 11,
  parameter int NARG = 5,
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rst_n_s,
  input logic            start,
  input logic            ret_en,
  input logic [XLEN-1:0] ret_val,
  input logic            wr_en,
  input logic            wr_sub,
  input logic [IDXW-1:0] wr_idx,
  input logic [IDXW-1:0] rd_idx_a,
  input logic [XLEN-1:0] rd_data_a,
  input logic            err,
  input logic [NREG-1:0] vld,
  input logic [XLEN-1:0] r0_q,
  input logic [XLEN-1:0] fp_q
);
  localparam int SUBW = XLEN / 2;
  localparam logic [NREG-1:0] START_MASK = {1'b1, {(NREG-3){1'b0}}, 2'b10};

  p_start_mask_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    start |=> (vld == START_MASK));

  p_sub_upper_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && wr_sub && !start && !ret_en && (wr_idx == '0)) |=> (r0_q[XLEN-1:SUBW] == '0));

  p_fp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    !start |=> $stable(fp_q));

  p_ret_args_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ret_en && !start) |=> (vld[NARG:1] == '0) && vld[0]);

  p_ret_value_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ret_en && !start) |=> (r0_q == $past(ret_val)));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (err && !start) |=> err);

  p_range_zero_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_idx_a >= NREG[IDXW-1:0]) |-> (rd_data_a == '0));
endmodule

bind pfx_regfile pfx_regfile_chk #(
  .XLEN(XLEN), .NREG(NREG), .NARG(NARG), .IDXW(IDXW)
) i_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .start     (start),
  .ret_en    (ret_en),
  .ret_val   (ret_val),
  .wr_en     (wr_en),
  .wr_sub    (wr_sub),
  .wr_idx    (wr_idx),
  .rd_idx_a  (rd_idx_a),
  .rd_data_a (rd_data_a),
  .err       (err),
  .vld       (rf_vld),
  .r0_q      (rf_q[0]),
  .fp_q      (rf_q[NREG-1])
);

// File: tb/test_pfx_regfile.sv
module test_pfx_regfile;
  localparam int XLEN = 64;
  localparam int NREG = 11;
  localparam int IDXW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic            start, ret_en, wr_en, wr_sub, rd_en_a, rd_en_b;
  logic [XLEN-1:0] ctx_ptr, frame_base, ret_val, wr_data;
  logic [IDXW-1:0] wr_idx, rd_idx_a, rd_idx_b;
  logic [XLEN-1:0] rd_data_a, rd_data_b;
  logic            err;

  pfx_regfile i_pfx_regfile (
    .clk(clk), .rst_n(rst_n), .start(start), .ctx_ptr(ctx_ptr),
    .frame_base(frame_base), .ret_en(ret_en), .ret_val(ret_val),
    .wr_en(wr_en), .wr_sub(wr_sub), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en_a(rd_en_a), .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
    .rd_en_b(rd_en_b), .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b),
    .err(err)
  );

  logic [XLEN-1:0] m_reg [NREG];
  logic            m_vld [NREG];
  logic            m_err;
  int checks = 0;
  int errors = 0;

  function automatic logic rd_ok(input logic [IDXW-1:0] idx);
    return (idx < NREG) && m_vld[idx];
  endfunction

  function automatic logic [XLEN-1:0] exp_rd(input logic [IDXW-1:0] idx);
    return rd_ok(idx) ? m_reg[idx] : '0;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) begin
      m_reg[i] = '0;
      m_vld[i] = (i == 1) || (i == NREG - 1);
    end
    m_err = 1'b0;
  endtask

  task automatic model_step();
    logic bad;
    if (start) begin
      for (int i = 0; i < NREG; i++) m_vld[i] = (i == 1) || (i == NREG - 1);
      m_reg[1]      = ctx_ptr;
      m_reg[NREG-1] = frame_base;
      m_err         = 1'b0;
    end else begin
      bad = (rd_en_a && !rd_ok(rd_idx_a)) || (rd_en_b && !rd_ok(rd_idx_b));
      if (ret_en) begin
        m_reg[0] = ret_val;
        m_vld[0] = 1'b1;
        for (int i = 1; i <= 5; i++) m_vld[i] = 1'b0;
      end else if (wr_en) begin
        if (wr_idx < NREG - 1) begin
          m_reg[wr_idx] = wr_sub ? {32'h0, wr_data[31:0]} : wr_data;
          m_vld[wr_idx] = 1'b1;
        end else begin
          bad = 1'b1;
        end
      end
      m_err = m_err | bad;
    end
  endtask

  task automatic idle();
    start = 0; ret_en = 0; wr_en = 0; wr_sub = 0; wr_idx = '0;
    rd_en_a = 0; rd_en_b = 0; rd_idx_a = '0; rd_idx_b = '0;
  endtask

  // caller sets inputs just after a falling edge
  task automatic cycle(input string tag);
    #1;
    chk(tag, "rd_data_a", rd_data_a, exp_rd(rd_idx_a));
    chk(tag, "rd_data_b", rd_data_b, exp_rd(rd_idx_b));
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag, "err", {63'h0, err}, {63'h0, m_err});
    idle();
  endtask

  task automatic rd(input string tag, input logic [IDXW-1:0] a, input logic [IDXW-1:0] b);
    rd_en_a = 1; rd_idx_a = a; rd_en_b = 1; rd_idx_b = b;
    cycle(tag);
  endtask

  task automatic wr(input string tag, input logic [IDXW-1:0] idx,
                    input logic sub, input logic [XLEN-1:0] d);
    wr_en = 1; wr_idx = idx; wr_sub = sub; wr_data = d;
    cycle(tag);
  endtask

  task automatic go(input string tag);
    start = 1;
    cycle(tag);
  endtask

  initial begin
    #1200000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    idle();
    ctx_ptr = 64'hC0DE_0000_0000_1000;
    frame_base = 64'h0000_7FFF_FFFF_E000;
    ret_val = '0;
    wr_data = '0;
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state, entries 1 and 10 readable with zero, err low
    chk("R1", "err after reset", {63'h0, err}, 64'h0);
    rd("R1", 4'd1, 4'd10);
    rd_en_a = 0; rd_idx_a = 4'd7; rd_en_b = 0; rd_idx_b = 4'd0; cycle("R1");
    rd("R1", 4'd3, 4'd1);

    // R2: start loads context and frame base, clears err
    go("R2");
    rd("R2", 4'd1, 4'd10);
    rd("R2", 4'd1, 4'd10);

    // R3: full writes; R10: same-cycle read returns old value
    wr("R3", 4'd7, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd("R3", 4'd7, 4'd1);
    wr_en = 1; wr_idx = 4'd7; wr_sub = 0; wr_data = 64'h0123_4567_89AB_CDEF;
    rd_en_a = 1; rd_idx_a = 4'd7; rd_en_b = 1; rd_idx_b = 4'd10;
    cycle("R10");
    rd("R10", 4'd10, 4'd7);

    // R4: subregister write over an all-ones value
    wr("R4", 4'd2, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    wr("R4", 4'd2, 1'b1, 64'hAAAA_BBBB_8765_4321);
    rd("R4", 4'd2, 4'd2);
    wr("R4", 4'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd("R4", 4'd0, 4'd1);

    // R5: writes to 10..15 ignored and flagged
    go("R5");
    wr("R5", 4'd10, 1'b0, 64'hDEAD_BEEF_DEAD_BEEF);
    rd("R5", 4'd10, 4'd10);
    wr("R5", 4'd15, 1'b1, 64'h1111);

    // R6 / R7: call return with every entry 0..9 readable
    go("R6");
    for (int i = 0; i < 10; i++) wr("R6", i[IDXW-1:0], 1'b0, 64'h5A00_0000_0000_0000 | i);
    ret_val = 64'h8000_0000_0000_0042;
    ret_en = 1; cycle("R6");
    rd("R6", 4'd0, 4'd6);
    rd("R7", 4'd6, 4'd9);
    rd("R7", 4'd7, 4'd8);
    rd("R6", 4'd3, 4'd5);
    rd("R6", 4'd1, 4'd9);

    // R9: priority start > ret > write
    go("R9");
    wr_en = 1; wr_idx = 4'd8; wr_data = 64'h99; ret_en = 1; ret_val = 64'h77;
    cycle("R9");
    rd("R9", 4'd0, 4'd10);
    go("R9");
    rd("R9", 4'd8, 4'd10);
    wr_en = 1; wr_idx = 4'd6; wr_data = 64'h66; start = 1;
    cycle("R9");
    rd("R9", 4'd6, 4'd1);
    go("R9");
    wr_en = 1; wr_idx = 4'd12; ret_en = 1; ret_val = 64'h3;
    cycle("R9");

    // R8: disabled read of unreadable entry: zero data, no err
    rd_en_a = 0; rd_idx_a = 4'd4; rd_en_b = 0; rd_idx_b = 4'd13; cycle("R8");
    rd("R8", 4'd13, 4'd0);
    rd("R8", 4'd0, 4'd0);
    go("R8");
    rd("R8", 4'd1, 4'd11);

    // random mix covering R3, R4, R6, R8, R10
    for (int n = 0; n < 4000; n++) begin
      start    = ($urandom_range(0, 40) == 0);
      ret_en   = ($urandom_range(0, 12) == 0);
      ret_val  = {$urandom, $urandom};
      ctx_ptr  = {$urandom, $urandom};
      frame_base = {$urandom, $urandom};
      wr_en    = $urandom_range(0, 1);
      wr_sub   = $urandom_range(0, 1);
      wr_idx   = ($urandom_range(0, 7) == 0) ? IDXW'($urandom_range(10, 15))
                                             : IDXW'($urandom_range(0, 9));
      wr_data  = {$urandom, $urandom};
      rd_en_a  = $urandom_range(0, 1);
      rd_en_b  = $urandom_range(0, 1);
      rd_idx_a = IDXW'($urandom_range(0, 15));
      rd_idx_b = IDXW'($urandom_range(0, 11));
      cycle("R3/R4/R6/R8/R10 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule